// File: doc/BRIEF.md
# Polynomial-Counter Audio Tone Generator

This block is one audio channel. It turns a slow base-rate tick into a 4-bit amplitude sample. The tick runs at roughly 30 kHz, which is twice the horizontal line rate. A 5-bit frequency value divides the tick stream by 1 to 32, and each divided pulse is a "step". A 4-bit control value chooses how steps are turned into a 1-bit waveform. The choices are a constant high level, three maximal-length shift-register sequences (4, 5 and 9 bits), fixed square dividers of 2, 6, 31 and 93 steps, and mixed forms in which one source clocks another. A 4-bit volume value gates the waveform bit onto the output.

Software writes the three registers through separate write strobes and feeds the base-rate tick. Mixing with a second channel, conversion to analog and generation of the tick are done elsewhere.

Top module: `audio_tone_gen`

## Requirements
- R1: After reset, amp_o is 0. The volume, control and frequency values are 0. All shift registers hold all ones. The divider count and the square toggle are 0.
- R2: With an active frequency value F, a step occurs on the tick at which the prescale count equals F, so one step is made every F+1 ticks. The count returns to 0 on each step.
- R3: amp_o equals the volume value while the waveform bit is 1, and equals 0 while it is 0.
- R4: Control values 0 and 11 hold the waveform bit at 1, so amp_o equals the volume value.
- R5: The shift registers shift left on each of their advances. The new low bit is the XOR of the top bit and bit 2 (4-bit and 5-bit) or bit 4 (9-bit), and the waveform bit is the top bit. Control 1 advances the 4-bit register on every step, giving period 15 with 8 ones. Control 9 advances the 5-bit register on every step, giving period 31 with 16 ones. Control 8 advances the 9-bit register on every step, giving period 511 with 256 ones.
- R6: Controls 4, 5, 6, 10, 12, 13 and 14 produce a square wave. A divide count advances on every step. Each time the count reaches N-1, the toggle flips and the count returns to 0. N is 2 for controls 4 and 5, 31 for controls 6 and 10, 6 for controls 12 and 13, and 93 for control 14. Any control write clears the count and the toggle.
- R7: Control 2 runs the divide count with N=15. The 4-bit register advances only on the step at which the count wraps, and its top bit is the waveform.
- R8: Control 3 advances the 5-bit register on every step. It advances the 4-bit register on steps where the 5-bit top bit, before that step, is 1. The 4-bit top bit is the waveform.
- R9: Controls 7 and 15 advance the 5-bit register on every step. The divide count (N=2 for 7, N=6 for 15) advances only on steps where the 5-bit top bit, before that step, is 1. The toggle is the waveform.
- R10: A frequency write is held and becomes the active divisor only at the next step. Until then, steps keep the old spacing.
- R11: A shift register not used by the current control value holds its state across steps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Base-rate tick, one cycle wide |
| freq_we_i | input | 1 | Frequency write strobe |
| freq_i | input | 5 | Frequency value (divide by value+1) |
| ctrl_we_i | input | 1 | Control write strobe |
| ctrl_i | input | 4 | Waveform source select |
| vol_we_i | input | 1 | Volume write strobe |
| vol_i | input | 4 | Volume value |
| amp_o | output | 4 | Amplitude sample |

## Verification
The bench sweeps all sixteen control values at three frequency settings and compares each tick against an arithmetic model. Wrong tap positions or a stuck register would change the measured periods and one-counts of the three sequences. An off-by-one in the prescaler or the dividers would shift every toggle edge. A frequency write applied at once, instead of at the next step, would break the spacing of the steps right after the write. A register that kept advancing under foreign control values would make its sequence resume at the wrong phase when its own control value returns.

// File: rtl/audio_tone_pkg.sv
package audio_tone_pkg;
  localparam int FREQ_W = 5;
  localparam int CTRL_W = 4;
  localparam int VOL_W  = 4;
  localparam int DC_W   = 7;

  typedef enum logic [2:0] {SRC_ONE, SRC_P4, SRC_P5, SRC_P9, SRC_TGL} src_e;

  function automatic src_e src_of(input logic [CTRL_W-1:0] c);
    case (c)
      4'd1, 4'd2, 4'd3: return SRC_P4;
      4'd8:             return SRC_P9;
      4'd9:             return SRC_P5;
      4'd0, 4'd11:      return SRC_ONE;
      default:          return SRC_TGL;
    endcase
  endfunction

  function automatic logic [DC_W-1:0] div_len(input logic [CTRL_W-1:0] c);
    case (c)
      4'd4, 4'd5, 4'd7:    return 7'd2;
      4'd12, 4'd13, 4'd15: return 7'd6;
      4'd6, 4'd10:         return 7'd31;
      4'd14:               return 7'd93;
      4'd2:                return 7'd15;
      default:             return 7'd1;
    endcase
  endfunction
endpackage

// File: rtl/tone_prescaler.sv
module tone_prescaler #(
  parameter int W = 5
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         tick_i,
  input  logic         freq_we_i,
  input  logic [W-1:0] freq_i,
  output logic         step_o
);
  logic [W-1:0] pend_q, div_q, cnt_q;
  logic         tc;

  assign tc     = (cnt_q == div_q);
  assign step_o = tick_i & tc;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= '0;
      div_q  <= '0;
      cnt_q  <= '0;
    end else begin
      if (freq_we_i) pend_q <= freq_i;
      if (tick_i) begin
        if (tc) begin
          cnt_q <= '0;
          div_q <= pend_q;  // reload only at terminal count
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  a_r2_cnt_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= div_q);
  a_r10_reload_at_tc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(tick_i && tc) |=> $stable(div_q));
  a_r2_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_o |=> cnt_q == '0);
endmodule

// File: rtl/tone_lfsr.sv
module tone_lfsr #(
  parameter int W   = 4,
  parameter int TAP = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         adv_i,
  output logic         bit_o
);
  logic [W-1:0] s_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    s_q <= '1;
    else if (adv_i) s_q <= {s_q[W-2:0], s_q[W-1] ^ s_q[TAP]};
  end

  assign bit_o = s_q[W-1];

  a_r5_never_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    s_q != '0);
  a_r11_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !adv_i |=> $stable(s_q));
endmodule

// File: rtl/tone_wave_src.sv
module tone_wave_src
  import audio_tone_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              step_i,
  input  logic              clr_i,
  input  logic [CTRL_W-1:0] ctrl_i,
  output logic              wave_o
);
  logic [DC_W-1:0] dc_q, n;
  logic            t_q, wrap, dc_cnt, div_mode, gated_mode;
  logic            p4_adv, p5_adv, p9_adv, p4_bit, p5_bit, p9_bit;
  src_e            src;

  assign src        = src_of(ctrl_i);
  assign n          = div_len(ctrl_i);
  assign wrap       = (dc_q >= n - 7'd1);
  assign gated_mode = (ctrl_i == 4'd7) || (ctrl_i == 4'd15);
  assign div_mode   = (src == SRC_TGL && !gated_mode) || (ctrl_i == 4'd2);
  assign dc_cnt     = step_i & (div_mode | (gated_mode & p5_bit));

  assign p4_adv = step_i & ((ctrl_i == 4'd1)
                          | ((ctrl_i == 4'd2) & wrap)
                          | ((ctrl_i == 4'd3) & p5_bit));
  assign p5_adv = step_i & ((ctrl_i == 4'd3) | (ctrl_i == 4'd9) | gated_mode);
  assign p9_adv = step_i & (ctrl_i == 4'd8);

  tone_lfsr #(.W(4), .TAP(2)) u_p4 (.clk_i, .rst_ni, .adv_i(p4_adv), .bit_o(p4_bit));
  tone_lfsr #(.W(5), .TAP(2)) u_p5 (.clk_i, .rst_ni, .adv_i(p5_adv), .bit_o(p5_bit));
  tone_lfsr #(.W(9), .TAP(4)) u_p9 (.clk_i, .rst_ni, .adv_i(p9_adv), .bit_o(p9_bit));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dc_q <= '0;
      t_q  <= 1'b0;
    end else if (clr_i) begin
      dc_q <= '0;
      t_q  <= 1'b0;
    end else if (dc_cnt) begin
      if (wrap) begin
        dc_q <= '0;
        t_q  <= ~t_q;
      end else begin
        dc_q <= dc_q + 7'd1;
      end
    end
  end

  always_comb begin
    case (src)
      SRC_P4:  wave_o = p4_bit;
      SRC_P5:  wave_o = p5_bit;
      SRC_P9:  wave_o = p9_bit;
      SRC_TGL: wave_o = t_q;
      default: wave_o = 1'b1;
    endcase
  end

  a_r6_dc_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dc_q < 7'd93);
  a_r6_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (dc_q == '0 && !t_q));
  a_r9_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gated_mode && !p5_bit && !clr_i) |=> $stable(dc_q));
endmodule

// File: rtl/audio_tone_gen.sv
module audio_tone_gen
  import audio_tone_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              freq_we_i,
  input  logic [FREQ_W-1:0] freq_i,
  input  logic              ctrl_we_i,
  input  logic [CTRL_W-1:0] ctrl_i,
  input  logic              vol_we_i,
  input  logic [VOL_W-1:0]  vol_i,
  output logic [VOL_W-1:0]  amp_o
);
  logic [CTRL_W-1:0] ctrl_q;
  logic [VOL_W-1:0]  vol_q;
  logic              step, wave;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      vol_q  <= '0;
    end else begin
      if (ctrl_we_i) ctrl_q <= ctrl_i;
      if (vol_we_i)  vol_q  <= vol_i;
    end
  end

  tone_prescaler #(.W(FREQ_W)) u_pre (
    .clk_i, .rst_ni, .tick_i, .freq_we_i, .freq_i, .step_o(step)
  );

  tone_wave_src u_src (
    .clk_i, .rst_ni, .step_i(step), .clr_i(ctrl_we_i), .ctrl_i(ctrl_q), .wave_o(wave)
  );

  assign amp_o = wave ? vol_q : '0;

  a_r4_const: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_q == 4'd0 || ctrl_q == 4'd11) |-> amp_o == vol_q);
  a_r3_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    amp_o == '0 || amp_o == vol_q);
endmodule

// File: tb/audio_tone_gen_bench.sv
module audio_tone_gen_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0, fwe = 1'b0, cwe = 1'b0, vwe = 1'b0;
  logic [4:0] freq = '0;
  logic [3:0] ctrl = '0, vol = '0;
  logic [3:0] amp;
  int         n_chk = 0, n_fail = 0;
  bit         done = 0;

  // model state
  logic [3:0] m_p4 = '1;
  logic [4:0] m_p5 = '1;
  logic [8:0] m_p9 = '1;
  int         m_dc = 0, m_cnt = 0, m_div = 0, m_pend = 0;
  logic       m_t = 1'b0;
  logic [3:0] m_ctrl = '0, m_vol = '0;

  always #2.5 clk = ~clk;

  audio_tone_gen u_audio_tone_gen (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .freq_we_i(fwe), .freq_i(freq),
    .ctrl_we_i(cwe), .ctrl_i(ctrl), .vol_we_i(vwe), .vol_i(vol), .amp_o(amp)
  );

  function automatic int nlen(input logic [3:0] c);
    case (c)
      4'd4, 4'd5, 4'd7:    return 2;
      4'd12, 4'd13, 4'd15: return 6;
      4'd6, 4'd10:         return 31;
      4'd14:               return 93;
      4'd2:                return 15;
      default:             return 1;
    endcase
  endfunction

  function automatic logic m_wave();
    case (m_ctrl)
      4'd0, 4'd11:      return 1'b1;
      4'd1, 4'd2, 4'd3: return m_p4[3];
      4'd8:             return m_p9[8];
      4'd9:             return m_p5[4];
      default:          return m_t;
    endcase
  endfunction

  function automatic string req_of(input logic [3:0] c);
    case (c)
      4'd0, 4'd11:      return "R4";
      4'd1, 4'd8, 4'd9: return "R5";
      4'd2:             return "R7";
      4'd3:             return "R8";
      4'd7, 4'd15:      return "R9";
      default:          return "R6";
    endcase
  endfunction

  task automatic check(input string tag);
    logic [3:0] exp;
    exp = m_wave() ? m_vol : 4'd0;
    n_chk++;
    if (amp !== exp) begin
      n_fail++;
      $display("FAIL %s ctrl=%0d amp=%0d expected=%0d", tag, m_ctrl, amp, exp);
    end
  endtask

  task automatic model_step();
    logic b5, wr, cnt, p4a;
    int   n;
    b5  = m_p5[4];
    n   = nlen(m_ctrl);
    wr  = (m_dc >= n - 1);
    cnt = (m_ctrl inside {4'd2, 4'd4, 4'd5, 4'd6, 4'd10, 4'd12, 4'd13, 4'd14})
        || ((m_ctrl == 4'd7 || m_ctrl == 4'd15) && b5);
    p4a = (m_ctrl == 4'd1) || (m_ctrl == 4'd2 && wr) || (m_ctrl == 4'd3 && b5);
    if (p4a) m_p4 = {m_p4[2:0], m_p4[3] ^ m_p4[2]};
    if (m_ctrl inside {4'd3, 4'd7, 4'd9, 4'd15}) m_p5 = {m_p5[3:0], m_p5[4] ^ m_p5[2]};
    if (m_ctrl == 4'd8) m_p9 = {m_p9[7:0], m_p9[8] ^ m_p9[4]};
    if (cnt) begin
      if (wr) begin m_dc = 0; m_t = ~m_t; end
      else m_dc++;
    end
  endtask

  task automatic do_tick();
    @(negedge clk) tick = 1'b1;
    @(negedge clk) tick = 1'b0;
    if (m_cnt == m_div) begin
      m_cnt = 0;
      m_div = m_pend;
      model_step();
    end else m_cnt++;
  endtask

  task automatic wr_freq(input int f);
    @(negedge clk) begin fwe = 1'b1; freq = f[4:0]; end
    @(negedge clk) fwe = 1'b0;
    m_pend = f;
  endtask

  task automatic wr_ctrl(input logic [3:0] c);
    @(negedge clk) begin cwe = 1'b1; ctrl = c; end
    @(negedge clk) cwe = 1'b0;
    m_ctrl = c; m_dc = 0; m_t = 1'b0;
  endtask

  task automatic wr_vol(input logic [3:0] v);
    @(negedge clk) begin vwe = 1'b1; vol = v; end
    @(negedge clk) vwe = 1'b0;
    m_vol = v;
  endtask

  // period and one-count of a shift-register mode at freq 0
  task automatic seq_check(input logic [3:0] c, input int per, input int ones, input string tag);
    logic s [0:1023];
    int   k;
    wr_freq(0); wr_ctrl(c); wr_vol(4'd1);
    do_tick();  // flush pending frequency
    for (int i = 0; i < 2 * per; i++) begin
      do_tick();
      check(tag);
      s[i] = (amp != 4'd0);
    end
    k = 0;
    for (int i = 0; i < per; i++) begin
      if (s[i]) k++;
      n_chk++;
      if (s[i] !== s[i + per]) begin
        n_fail++;
        $display("FAIL %s period idx=%0d actual=%0b expected=%0b", tag, i, s[i + per], s[i]);
      end
    end
    n_chk++;
    if (k != ones) begin
      n_fail++;
      $display("FAIL %s ones actual=%0d expected=%0d", tag, k, ones);
    end
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    n_chk++;
    if (amp !== 4'd0) begin
      n_fail++;
      $display("FAIL R1 reset amp=%0d expected=0", amp);
    end
    rst_n = 1'b1;
    @(negedge clk);
    check("R1");

    // R4 R3: constant level with a volume
    wr_vol(4'd9);
    check("R4 R3");

    // R2 R3 sweep of every control value at several divisors
    for (int c = 0; c < 16; c++) begin
      foreach (freq_set[j]) begin
        wr_freq(freq_set[j]);
        wr_ctrl(c[3:0]);
        wr_vol(c[3:0] ^ 4'd5 | 4'd1);
        for (int t = 0; t < 48; t++) begin
          do_tick();
          check({req_of(c[3:0]), " R2 R3"});
        end
      end
    end

    // R5 periods and balance
    seq_check(4'd1, 15, 8, "R5 p4");
    seq_check(4'd9, 31, 16, "R5 p5");
    seq_check(4'd8, 511, 256, "R5 p9");

    // R6 exact divide-by-2 pattern at freq 0
    wr_freq(0); wr_ctrl(4'd4); wr_vol(4'd7);
    do_tick();
    check("R6");
    begin
      logic [3:0] pat [0:5];
      wr_ctrl(4'd4);
      pat[0] = 4'd0; pat[1] = 4'd7; pat[2] = 4'd7;
      pat[3] = 4'd0; pat[4] = 4'd0; pat[5] = 4'd7;
      for (int i = 0; i < 6; i++) begin
        do_tick();
        check("R6");
        n_chk++;
        if (amp !== pat[i]) begin
          n_fail++;
          $display("FAIL R6 pattern idx=%0d amp=%0d expected=%0d", i, amp, pat[i]);
        end
      end
    end

    // R11 registers hold while another mode runs
    wr_ctrl(4'd1);
    repeat (5) begin do_tick(); check("R11"); end
    wr_ctrl(4'd12);
    repeat (9) begin do_tick(); check("R11"); end
    wr_ctrl(4'd1);
    repeat (10) begin do_tick(); check("R11"); end

    // R10 frequency change mid-count takes effect at next step
    wr_ctrl(4'd4); wr_freq(7);
    repeat (3) begin do_tick(); check("R10"); end
    wr_freq(0);
    repeat (20) begin do_tick(); check("R10"); end
    wr_freq(2);
    do_tick(); check("R10");
    wr_freq(5);
    repeat (30) begin do_tick(); check("R10"); end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  int freq_set [3] = '{0, 1, 3};
endmodule